// File: doc/BRIEF.md
# EEPROM Byte-Write Polling Engine

This block copies a block of up to 256 bytes from a synchronous source memory into a parallel EEPROM, one byte per write cycle. Write completion is not timed. After each write the engine reads the same EEPROM address back until the returned byte equals the byte it wrote. Polls are spaced by a fixed delay. A bounded poll count turns a device that never finishes into an error flag, so the engine cannot hang.

A controller loads a source base address, an EEPROM base address and a byte count, then pulses start. The engine stays busy until every byte has verified, or until one byte has used up its poll budget. It then pulses done for one cycle. The error flag shows which of the two outcomes ended the run.

Top module: `eeprom_poll_writer`

## Requirements
- R1: For each byte offset i, taken in ascending order from 0, the engine first asserts `src_rd_o` for one cycle with `src_addr_o` = source base + i. It samples `src_data_i` on the following cycle. It then asserts `ee_we_o` for exactly one cycle with `ee_addr_o` = EEPROM base + i and `ee_wdata_o` equal to that sampled byte.
- R2: The cycle right after a write is a poll: `ee_oe_o` is high at the same address. A byte counts as complete only when `ee_rdata_i` equals the written byte in all bits during a poll cycle. Only then does the engine move on to the next byte.
- R3: From a write until its matching poll, the only EEPROM access is a read of the written address. `ee_we_o` and `ee_oe_o` are never high together.
- R4: If 256 polls of one byte all miss, the engine stops right after the 256th poll. It sets `error_o` and pulses `done_o`, and it makes no further source or EEPROM access.
- R5: Between two consecutive polls of the same byte there are exactly POLL_DELAY cycles in which neither `ee_we_o` nor `ee_oe_o` is high. Two poll cycles are therefore POLL_DELAY+1 cycles apart.
- R6: `count_i` values 1 to 255 transfer that many bytes, and 0 transfers 256. The 8-bit offset is added to both bases. The EEPROM address wraps within 13 bits. No EEPROM byte outside the range is written.
- R7: `busy_o` is high from the cycle after an accepted start until the run ends. When all bytes verify, `done_o` is high for exactly one cycle, with `busy_o` low and `error_o` low.
- R8: `error_o` stays set after a failed run and is cleared when the next start is accepted.
- R9: `start_i` has no effect while `busy_o` is high. The run in progress keeps its bases and its count.
- R10: During reset `busy_o`, `done_o`, `error_o`, `src_rd_o`, `ee_we_o` and `ee_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled while idle |
| count_i | input | IDX_W | Byte count, 0 means 256 |
| src_base_i | input | SRC_AW | Source base address |
| ee_base_i | input | EE_AW | EEPROM base address |
| src_rd_o | output | 1 | Source read strobe |
| src_addr_o | output | SRC_AW | Source read address |
| src_data_i | input | DATA_W | Source data, valid the cycle after the strobe |
| ee_we_o | output | 1 | EEPROM write strobe |
| ee_oe_o | output | 1 | EEPROM read (poll) strobe |
| ee_addr_o | output | EE_AW | EEPROM address |
| ee_wdata_o | output | DATA_W | EEPROM write data |
| ee_rdata_i | input | DATA_W | EEPROM read data, sampled in poll cycles |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| error_o | output | 1 | Latched timeout flag |

## Verification
The assertions assume the source returns data one cycle after its strobe. They also assume `ee_rdata_i` settles within the poll cycle, and that the inter-poll delay is at least one cycle. The bench's source model is a registered function of the address, and its EEPROM model answers reads combinationally. While a write is still in progress, the model returns the complement of the written byte, for a programmable number of cycles or forever. Random latencies are therefore well inside the poll budget. Directed runs sit exactly on the 256th poll and one cycle beyond it.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SRC,
    ST_CAP,
    ST_WR,
    ST_POLL,
    ST_DLY,
    ST_NEXT
  } state_e;
endpackage

// File: rtl/eepw_delay.sv
module eepw_delay #(
  parameter int DELAY = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(DELAY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  // delay is counted out before the next poll
  assert_run_not_expired_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> !expired_o);
endmodule

// File: rtl/eepw_poll_ctr.sv
module eepw_poll_ctr #(
  parameter int POLL_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [POLL_W-1:0] cnt_o,
  output logic              last_o
);
  logic [POLL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = &cnt_q;

  // controller must give up instead of wrapping
  assert_no_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/eepw_addr_gen.sv
module eepw_addr_gen #(
  parameter int SRC_AW = 16,
  parameter int EE_AW  = 13,
  parameter int IDX_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [SRC_AW-1:0] src_base_i,
  input  logic [EE_AW-1:0]  ee_base_i,
  input  logic [IDX_W-1:0]  count_i,
  output logic [SRC_AW-1:0] src_addr_o,
  output logic [EE_AW-1:0]  ee_addr_o,
  output logic              last_o
);
  logic [SRC_AW-1:0] src_base_q;
  logic [EE_AW-1:0]  ee_base_q;
  logic [IDX_W-1:0]  idx_q, last_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_base_q <= '0;
      ee_base_q  <= '0;
      idx_q      <= '0;
      last_idx_q <= '0;
    end else if (load_i) begin
      src_base_q <= src_base_i;
      ee_base_q  <= ee_base_i;
      idx_q      <= '0;
      last_idx_q <= count_i - IDX_W'(1);  // 0 wraps to full range
    end else if (step_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign src_addr_o = src_base_q + SRC_AW'(idx_q);
  assign ee_addr_o  = ee_base_q + EE_AW'(idx_q);
  assign last_o     = (idx_q == last_idx_q);

  assert_step_in_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);
endmodule

// File: rtl/eeprom_poll_writer.sv
module eeprom_poll_writer
  import eepw_pkg::*;
#(
  parameter int SRC_AW     = 16,
  parameter int EE_AW      = 13,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 8,
  parameter int POLL_W     = 8,
  parameter int POLL_DELAY = 2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [IDX_W-1:0]  count_i,
  input  logic [SRC_AW-1:0] src_base_i,
  input  logic [EE_AW-1:0]  ee_base_i,
  output logic              src_rd_o,
  output logic [SRC_AW-1:0] src_addr_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              ee_we_o,
  output logic              ee_oe_o,
  output logic [EE_AW-1:0]  ee_addr_o,
  output logic [DATA_W-1:0] ee_wdata_o,
  input  logic [DATA_W-1:0] ee_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  state_e state_q, state_d;
  logic [DATA_W-1:0] data_q;
  logic done_q, error_q;
  logic done_set, err_set, err_clr;
  logic ag_load, ag_step, ag_last;
  logic pc_clr, pc_inc, pc_last;
  logic dl_load, dl_run, dl_expired;
  logic match_w;
  logic [POLL_W-1:0] poll_cnt;

  eepw_addr_gen #(.SRC_AW(SRC_AW), .EE_AW(EE_AW), .IDX_W(IDX_W)) u_addr (
    .clk_i, .rst_ni,
    .load_i(ag_load), .step_i(ag_step),
    .src_base_i, .ee_base_i, .count_i,
    .src_addr_o, .ee_addr_o, .last_o(ag_last)
  );

  eepw_poll_ctr #(.POLL_W(POLL_W)) u_poll (
    .clk_i, .rst_ni,
    .clr_i(pc_clr), .inc_i(pc_inc),
    .cnt_o(poll_cnt), .last_o(pc_last)
  );

  eepw_delay #(.DELAY(POLL_DELAY)) u_delay (
    .clk_i, .rst_ni,
    .load_i(dl_load), .run_i(dl_run), .expired_o(dl_expired)
  );

  assign match_w = (ee_rdata_i == data_q);

  always_comb begin
    state_d  = state_q;
    src_rd_o = 1'b0;
    ee_we_o  = 1'b0;
    ee_oe_o  = 1'b0;
    ag_load  = 1'b0;
    ag_step  = 1'b0;
    pc_clr   = 1'b0;
    pc_inc   = 1'b0;
    dl_load  = 1'b0;
    dl_run   = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ag_load = 1'b1;
        err_clr = 1'b1;
        state_d = ST_SRC;
      end
      ST_SRC: begin
        src_rd_o = 1'b1;
        state_d  = ST_CAP;
      end
      ST_CAP: state_d = ST_WR;
      ST_WR: begin
        ee_we_o = 1'b1;
        pc_clr  = 1'b1;
        state_d = ST_POLL;
      end
      ST_POLL: begin
        ee_oe_o = 1'b1;
        if (match_w) begin
          state_d = ST_NEXT;
        end else if (pc_last) begin
          err_set  = 1'b1;
          done_set = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          pc_inc  = 1'b1;
          dl_load = 1'b1;
          state_d = ST_DLY;
        end
      end
      ST_DLY: begin
        if (dl_expired) state_d = ST_POLL;
        else            dl_run  = 1'b1;
      end
      ST_NEXT: begin
        if (ag_last) begin
          done_set = 1'b1;
          state_d  = ST_IDLE;
        end else begin
          ag_step = 1'b1;
          state_d = ST_SRC;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      done_q  <= 1'b0;
      error_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_set;
      if (state_q == ST_CAP) data_q <= src_data_i;
      if (err_clr)      error_q <= 1'b0;
      else if (err_set) error_q <= 1'b1;
    end
  end

  assign ee_wdata_o = data_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign error_o    = error_q;

  assert_we_oe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ee_we_o && ee_oe_o));

  assert_write_then_poll_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ee_we_o |=> ee_oe_o && $stable(ee_addr_o));

  assert_poll_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ee_oe_o && !match_w && !pc_last) |=> (!ee_oe_o && !ee_we_o));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_error_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> done_o);

  assert_quiet_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(ee_we_o || ee_oe_o || src_rd_o));

  assert_start_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

// File: tb/eeprom_poll_writer_tb_top.sv
module eeprom_poll_writer_tb_top;
  localparam int D   = 8;
  localparam int MSZ = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start;
  logic [7:0]  count;
  logic [15:0] src_base;
  logic [12:0] ee_base;
  logic        src_rd;
  logic [15:0] src_addr;
  logic [7:0]  src_data;
  logic        ee_we, ee_oe;
  logic [12:0] ee_addr;
  logic [7:0]  ee_wdata, ee_rdata;
  logic        busy, done, error;

  eeprom_poll_writer #(.POLL_DELAY(D)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .count_i(count),
    .src_base_i(src_base), .ee_base_i(ee_base),
    .src_rd_o(src_rd), .src_addr_o(src_addr), .src_data_i(src_data),
    .ee_we_o(ee_we), .ee_oe_o(ee_oe), .ee_addr_o(ee_addr),
    .ee_wdata_o(ee_wdata), .ee_rdata_i(ee_rdata),
    .busy_o(busy), .done_o(done), .error_o(error)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // source model: registered function of address
  logic [7:0] seed = 8'h00;
  function automatic logic [7:0] src_fn(input logic [7:0] s, input logic [15:0] a);
    logic [7:0] m;
    m = a[15:8] * 8'd29;
    return a[7:0] ^ m ^ s ^ 8'h3c;
  endfunction

  always @(posedge clk) if (src_rd) src_data <= src_fn(seed, src_addr);

  // EEPROM model: complemented data while write in progress
  logic [7:0]  mem [MSZ];
  int          busy_cnt = 0;
  int          lat = 0;
  logic        never = 1'b0;
  logic [12:0] lw_addr = '0;
  logic [7:0]  lw_data = '0;

  always @(posedge clk) begin
    if (ee_we) begin
      mem[ee_addr[9:0]] <= ee_wdata;
      lw_addr  <= ee_addr;
      lw_data  <= ee_wdata;
      busy_cnt <= lat;
    end else if (busy_cnt > 0) begin
      busy_cnt <= busy_cnt - 1;
    end
  end

  assign ee_rdata = ((busy_cnt != 0 || never) && ee_addr == lw_addr) ? ~lw_data
                                                                      : mem[ee_addr[9:0]];

  // port monitors
  int n_wr, n_poll, n_done, wr_bad, rd_bad, gap_bad, idle_bad, gap;
  bit in_poll, err_at_done;
  logic [15:0] r_src;
  logic [12:0] r_ee;

  always @(negedge clk) if (rst_n) begin
    if (ee_we) begin
      if (ee_addr != r_ee + 13'(n_wr) || ee_wdata != src_fn(seed, r_src + 16'(n_wr)))
        wr_bad++;
      n_wr++;
      in_poll = 1'b0;
    end
    if (ee_oe) begin
      n_poll++;
      if (ee_addr != lw_addr) rd_bad++;
      if (in_poll && gap != D + 1) gap_bad++;
      in_poll = 1'b1;
      gap = 0;
    end
    gap++;
    if (!busy && (ee_we || ee_oe || src_rd)) idle_bad++;
    if (done) begin
      n_done++;
      err_at_done = error;
    end
  end

  task automatic run(input logic [15:0] sb, input logic [12:0] eb, input logic [7:0] cnt,
                     input int latency, input bit nev, input bit stray);
    int nbytes, p, exp_wr, exp_poll, bad;
    bit exp_err;
    for (int i = 0; i < MSZ; i++) mem[i] <= 8'h5a;
    seed = 8'($urandom);
    lat = latency;
    never = nev;
    r_src = sb;
    r_ee = eb;
    n_wr = 0; n_poll = 0; n_done = 0; wr_bad = 0; rd_bad = 0;
    gap_bad = 0; idle_bad = 0; in_poll = 1'b0; gap = 0; err_at_done = 1'b0;
    @(negedge clk);
    start = 1'b1; src_base = sb; ee_base = eb; count = cnt;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
    chk(error == 1'b0, "R8 error cleared by start", int'(error), 0);
    if (stray) begin
      repeat (3) @(negedge clk);
      start = 1'b1; src_base = sb ^ 16'h0f0f; ee_base = eb ^ 13'h0155; count = cnt + 8'd7;
      @(negedge clk);
      start = 1'b0;
    end
    while (n_done == 0) @(negedge clk);
    repeat (4) @(negedge clk);

    nbytes = (cnt == 0) ? 256 : int'(cnt);
    p = (latency + D) / (D + 1) + 1;
    exp_err = nev || (p > 256);
    exp_wr = exp_err ? 1 : nbytes;
    exp_poll = exp_err ? 256 : nbytes * p;

    chk(n_done == 1, "R7 single done pulse", n_done, 1);
    chk(err_at_done == exp_err, "R4 error at done", int'(err_at_done), int'(exp_err));
    chk(error == exp_err, "R8 error latched", int'(error), int'(exp_err));
    chk(busy == 1'b0, "R7 idle after done", int'(busy), 0);
    chk(n_wr == exp_wr, "R6 write count", n_wr, exp_wr);
    chk(wr_bad == 0, "R1 write address/data", wr_bad, 0);
    chk(n_poll == exp_poll, "R2 poll count", n_poll, exp_poll);
    chk(rd_bad == 0, "R3 poll address", rd_bad, 0);
    chk(gap_bad == 0, "R5 poll spacing", gap_bad, 0);
    chk(idle_bad == 0, "R4 no access when idle", idle_bad, 0);
    if (!exp_err) begin
      bad = 0;
      for (int i = 0; i < nbytes; i++)
        if (mem[10'(eb + 13'(i))] != src_fn(seed, sb + 16'(i))) bad++;
      chk(bad == 0, "R6 EEPROM contents", bad, 0);
      chk(mem[10'(eb + 13'(nbytes))] == 8'h5a, "R6 byte past end untouched",
          int'(mem[10'(eb + 13'(nbytes))]), 'h5a);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    start = 1'b0; count = '0; src_base = '0; ee_base = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error, "R10 status in reset", int'({busy, done, error}), 0);
    chk(!src_rd && !ee_we && !ee_oe, "R10 strobes in reset", int'({src_rd, ee_we, ee_oe}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(16'h2100, 13'h0000, 8'd16, 0, 1'b0, 1'b0);        // immediate completion
    run(16'h0400, 13'h1ff8, 8'd20, 25, 1'b0, 1'b0);       // EEPROM address wrap
    for (int k = 0; k < 6; k++)
      run(16'($urandom), 13'($urandom), 8'($urandom_range(1, 40)),
          int'($urandom_range(0, 40)), 1'b0, 1'b0);
    run(16'h8000, 13'h0100, 8'd1, 255 * (D + 1), 1'b0, 1'b0);     // 256th poll hits
    run(16'h8000, 13'h0100, 8'd1, 255 * (D + 1) + 1, 1'b0, 1'b0); // one cycle too slow
    run(16'h1234, 13'h0200, 8'd5, 0, 1'b1, 1'b0);                // device never completes
    run(16'h3300, 13'h0040, 8'd30, 12, 1'b0, 1'b1);              // start while busy ignored
    run(16'hfff0, 13'h0300, 8'd0, 3, 1'b0, 1'b0);                // count 0 means 256
    run(16'h0001, 13'h0003, 8'd255, 0, 1'b0, 1'b0);              // maximum nonzero count

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule